// File: doc/BRIEF.md
# Compare and PWM Output Channel

This block is a single output channel that sits beside a time-base counter. Each clock it compares the counter's present value against a programmable compare value and updates one registered output pin. A 3-bit mode field picks the action: drive the active level on a match, drive the inactive level on a match, toggle on a match, or one of two pulse-width modes. In the pulse-width modes the level follows whether the count is still below the compare value. A polarity bit chooses which logic level counts as active. An enable bit gates the pin to the inactive level.

Every compare match sets a sticky flag. The flag raises an interrupt request when the channel's interrupt enable is set, and it stays set until it is cleared. Writes to the compare value can take effect at once. With preload switched on, a write is held in a buffer and moved to the live compare value only on the time-base's update pulse. A duty-cycle change then lands on a period boundary and never cuts a pulse short.

The counter, its reload value and the update pulse belong to the surrounding timer and arrive as inputs.

Top module: `cmpout_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pin`, `flag` and `irq` are 0 after that edge, and the live compare value is 0.
- R2: A compare match occurs in any cycle where `count` equals the live compare value. The clock edge that ends that cycle sets `flag`. `flag` stays set until a cycle with `flag_clr` high and no match. A match in the same cycle as `flag_clr` leaves `flag` set.
- R3: `irq` is high exactly when `flag` is high and `irq_en` is high.
- R4: Mode 3'b001 sets the internal level to active on a match. Mode 3'b010 sets it to inactive on a match. Mode 3'b011 inverts it on a match. With no match, these modes keep the level unchanged.
- R5: Mode 3'b110 makes the level active for each cycle in which `count` is below the live compare value. Over a period of reload+1 counts, that gives min(compare, reload+1) active cycles: 0 for compare 0, and the full period for a compare value above the reload value.
- R6: Mode 3'b111 is the inverse of R5: the level is active when `count` is at or above the live compare value.
- R7: Modes 3'b000, 3'b100 and 3'b101 keep the internal level at its current value.
- R8: With `polarity` 0 the active level is 1. With `polarity` 1 the active level is 0. The inactive level is always the opposite of the active level.
- R9: The pin is registered and reflects the inputs of the previous cycle. While `chan_en` was 0 in that cycle, `pin` equals `polarity` (the inactive level). The internal level keeps evolving while the pin is gated.
- R10: With `preload_en` 0, a write (`cmp_wr` high) becomes the live compare value at the clock edge that ends the write cycle, even in the middle of a period.
- R11: With `preload_en` 1, a write goes only to a buffer. The live value changes only at an edge that ends a cycle with `update` high. It then takes the value written in that same cycle if there is one, and the buffered value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count | input | CNT_W | Present value of the time-base counter |
| update | input | 1 | Update event pulse from the time base (period boundary) |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| preload_en | input | 1 | 1: buffer compare writes until the next update |
| mode | input | 3 | Output action select (encodings in R4 to R7) |
| polarity | input | 1 | 0: active high, 1: active low |
| chan_en | input | 1 | Pin enable; 0 holds the inactive level |
| irq_en | input | 1 | Channel interrupt enable |
| flag_clr | input | 1 | Clears the sticky match flag |
| pin | output | 1 | Registered channel output |
| flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a compare write that falls in the same cycle as the update pulse while preload is on. A close second is a write that lands mid-period without preload. Both depend on where the write falls relative to the period boundary.

The bench drives the count itself. It places the write strobe at a chosen count index inside a period, including the last index, where the update pulse is high. It then checks the active-cycle count of the surrounding periods against the arithmetic duty expected for the old and new values. A sweep over every mode, every compare value of a 4-bit counter and both polarities covers the 0 % and 100 % duty corners. Alongside the duty checks, a per-cycle expected model covers the flag, the interrupt and the gated pin.

// File: rtl/cmpout_pkg.sv
// Shared definitions for the compare/PWM output channel.
// Holds the mode encoding and the next-level rule used by the waveform stage.
package cmpout_pkg;

    typedef enum logic [2:0] {
        OC_FROZEN    = 3'b000,
        OC_SET_ACT   = 3'b001,
        OC_SET_INACT = 3'b010,
        OC_TOGGLE    = 3'b011,
        OC_RSV_A     = 3'b100,
        OC_RSV_B     = 3'b101,
        OC_PWM_LO    = 3'b110,
        OC_PWM_HI    = 3'b111
    } oc_mode_e;

    // Next internal (pre-polarity) level for a given mode and compare result.
    function automatic logic oc_next_level(oc_mode_e m, logic cur,
                                           logic hit, logic below);
        logic nxt;
        nxt = cur;
        case (m)
            OC_SET_ACT:   if (hit) nxt = 1'b1;
            OC_SET_INACT: if (hit) nxt = 1'b0;
            OC_TOGGLE:    if (hit) nxt = ~cur;
            OC_PWM_LO:    nxt = below;
            OC_PWM_HI:    nxt = ~below;
            default:      nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cmpout_shadow.sv
// Compare value storage: a write buffer plus the live value used by the comparator.
// Assumes update is a single-cycle pulse marking the period boundary.
// With preload off, writes reach the live value directly; with it on, only on update.
module cmpout_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             preload_en,
    input  logic             update,
    output logic [CNT_W-1:0] cmp_live
);

    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] buf_next;

    // The buffer always follows writes so turning preload on later is consistent.
    always_comb buf_next = wr_en ? wr_data : buf_q;

    // Buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_next;
    end

    // Live value: immediate load, or transfer on update when preloading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_live <= '0;
        end else if (!preload_en) begin
            if (wr_en) cmp_live <= wr_data;
        end else if (update) begin
            cmp_live <= buf_next;
        end
    end

endmodule

// File: rtl/cmpout_event.sv
// Compare detection and sticky match flag.
// Assumes count and cmp_live are stable through the cycle; produces the
// equality and below-compare results for the waveform stage.
module cmpout_event #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_live,
    input  logic             flag_clr,
    output logic             hit,
    output logic             below,
    output logic             flag
);

    // Equality and magnitude compare against the live value.
    always_comb begin
        hit   = (count == cmp_live);
        below = (count < cmp_live);
    end

    // Sticky flag: a match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/cmpout_wave.sv
// Waveform stage: keeps the internal level and drives the registered pin.
// Assumes hit and below describe the count of the current cycle; the pin
// shows that cycle's result one edge later, with gating and polarity applied.
module cmpout_wave
    import cmpout_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       hit,
    input  logic       below,
    input  logic       polarity,
    input  logic       chan_en,
    output logic       pin
);

    logic level_q;
    logic level_next;

    // Next internal level from the selected mode.
    always_comb level_next = oc_next_level(oc_mode_e'(mode), level_q, hit, below);

    // Internal level register; evolves even while the pin is gated.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_next;
    end

    // Pin register: gated to inactive, then polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= (chan_en & level_next) ^ polarity;
    end

endmodule

// File: rtl/cmpout_channel.sv
// Top of the compare/PWM output channel.
// Assumes count comes from an external time-base counter and update pulses
// once per period. Connects compare storage, match detection and the waveform stage.
module cmpout_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             update,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             preload_en,
    input  logic [2:0]       mode,
    input  logic             polarity,
    input  logic             chan_en,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             pin,
    output logic             flag,
    output logic             irq
);

    logic [CNT_W-1:0] cmp_live;
    logic             hit;
    logic             below;

    cmpout_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cmp_wr),
        .wr_data    (cmp_wdata),
        .preload_en (preload_en),
        .update     (update),
        .cmp_live   (cmp_live)
    );

    cmpout_event #(.CNT_W(CNT_W)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .cmp_live (cmp_live),
        .flag_clr (flag_clr),
        .hit      (hit),
        .below    (below),
        .flag     (flag)
    );

    cmpout_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .hit      (hit),
        .below    (below),
        .polarity (polarity),
        .chan_en  (chan_en),
        .pin      (pin)
    );

    // Interrupt request from the sticky flag.
    always_comb irq = flag & irq_en;

endmodule

// File: rtl/cmpout_checker.sv
// Property checker for cmpout_channel, attached with bind below.
module cmpout_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp_live,
    input logic             update,
    input logic             preload_en,
    input logic [2:0]       mode,
    input logic             polarity,
    input logic             chan_en,
    input logic             flag_clr,
    input logic             pin,
    input logic             flag
);

    assert_match_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp_live) |=> flag);

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_pwm_lo_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b110 && chan_en && count < cmp_live) |=> (pin == !$past(polarity)));

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000 && chan_en && $past(chan_en) && $stable(polarity)) |=> $stable(pin));

    assert_gated_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (pin == $past(polarity)));

    assert_preload_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !update) |=> $stable(cmp_live));

endmodule

bind cmpout_channel cmpout_checker #(.CNT_W(CNT_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .cmp_live   (cmp_live),
    .update     (update),
    .preload_en (preload_en),
    .mode       (mode),
    .polarity   (polarity),
    .chan_en    (chan_en),
    .flag_clr   (flag_clr),
    .pin        (pin),
    .flag       (flag)
);

// File: tb/cmpout_channel_bench.sv
`timescale 1ns/1ps
module cmpout_channel_bench;

    localparam int W      = 4;
    localparam int RELOAD = 11;
    localparam int PERIOD = RELOAD + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         upd = 1'b0;
    logic         wr = 1'b0;
    logic [W-1:0] wd = '0;
    logic         pre = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic         pol = 1'b0;
    logic         en = 1'b0;
    logic         ien = 1'b0;
    logic         clr = 1'b0;
    logic         pin, flag, irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 0;

    // Expected state, from the requirements
    logic         m_ref = 0, m_pin = 0, m_flag = 0;
    logic [W-1:0] m_act = '0, m_buf = '0;

    always #2 clk = ~clk;

    cmpout_channel #(.CNT_W(W)) u_cmpout_channel (
        .clk(clk), .rst_n(rst_n), .count(cnt), .update(upd),
        .cmp_wr(wr), .cmp_wdata(wd), .preload_en(pre), .mode(mode),
        .polarity(pol), .chan_en(en), .irq_en(ien), .flag_clr(clr),
        .pin(pin), .flag(flag), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // One clock: predict, clock, compare, then drive the next inputs.
    task automatic cycle();
        logic hit, below, n_ref, n_pin, n_flag;
        logic [W-1:0] n_act, n_buf;
        string tag;
        hit   = (cnt == m_act);
        below = (cnt < m_act);
        n_ref = m_ref;
        case (mode)
            3'b001: if (hit) n_ref = 1'b1;   // R4
            3'b010: if (hit) n_ref = 1'b0;
            3'b011: if (hit) n_ref = ~m_ref;
            3'b110: n_ref = below;           // R5
            3'b111: n_ref = ~below;          // R6
            default: ;                       // R7
        endcase
        n_pin  = (en & n_ref) ^ pol;
        n_flag = hit | (m_flag & ~clr);
        n_buf  = wr ? wd : m_buf;
        if (!pre)     n_act = wr ? wd : m_act;
        else if (upd) n_act = n_buf;
        else          n_act = m_act;
        if (!en)                                   tag = "R9";
        else if (mode == 3'b110)                   tag = "R5";
        else if (mode == 3'b111)                   tag = "R6";
        else if (mode inside {3'b001,3'b010,3'b011}) tag = "R4";
        else                                       tag = "R7";
        @(posedge clk); #1;
        cyc++;
        m_ref = n_ref; m_pin = n_pin; m_flag = n_flag; m_act = n_act; m_buf = n_buf;
        check(pin == m_pin, {tag, " pin"}, pin, m_pin);
        check(flag == m_flag, "R2 flag", flag, m_flag);
        check(irq == (m_flag & ien), "R3 irq", irq, m_flag & ien);
        wr  = 1'b0;
        cnt = (cnt == RELOAD) ? '0 : cnt + 1'b1;
        upd = (cnt == RELOAD);
        clr = (cyc % 7 == 3);
        ien = (cyc % 4 != 0);
    endtask

    // Runs one period from count 0; optional write at index wr_at; returns active cycles.
    task automatic run_period(input int wr_at, input int wr_val, output int act);
        act = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (i == wr_at) begin
                wr = 1'b1;
                wd = W'(wr_val);
            end
            cycle();
            if (pin != pol) act++;
        end
    endtask

    function automatic int pwm_lo_duty(input int c);
        return (c < PERIOD) ? c : PERIOD;
    endfunction

    initial begin
        int a;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check(pin == 1'b0, "R1 pin", pin, 0);
            check(flag == 1'b0, "R1 flag", flag, 0);
            check(irq == 1'b0, "R1 irq", irq, 0);
        end
        rst_n = 1'b1;

        // Sweep: both polarities, all mode codes, every compare value
        for (int p = 0; p < 2; p++) begin
            for (int md = 0; md < 8; md++) begin
                for (int c = 0; c < (1 << W); c++) begin
                    run_period(RELOAD, c, a);        // load compare at boundary
                    mode = 3'(md); pol = p[0]; en = 1'b1;
                    run_period(-1, 0, a);
                    if (md == 6) check(a == pwm_lo_duty(c), "R10 duty after write", a, pwm_lo_duty(c));
                    en = 1'b0;
                    run_period(-1, 0, a);            // gated: R9 per cycle
                    check(a == 0, "R9 gated active cycles", a, 0);
                    en = 1'b1;
                    run_period(-1, 0, a);
                    if (md == 6) check(a == pwm_lo_duty(c), p ? "R8 R5 duty" : "R5 duty", a, pwm_lo_duty(c));
                    if (md == 7) check(a == PERIOD - pwm_lo_duty(c), p ? "R8 R6 duty" : "R6 duty", a, PERIOD - pwm_lo_duty(c));
                end
            end
        end

        // R10: immediate write mid-period
        pol = 1'b0; mode = 3'b110; pre = 1'b0;
        run_period(RELOAD, 6, a);
        run_period(5, 12, a);
        check(a == 12, "R10 mid-period write", a, 12);

        // R11: preloaded write held to boundary, then write coinciding with update
        run_period(RELOAD, 3, a);
        pre = 1'b1;
        run_period(5, 9, a);
        check(a == 3, "R11 buffered write", a, 3);
        run_period(RELOAD, 6, a);
        check(a == 9, "R11 transfer on update", a, 9);
        run_period(-1, 0, a);
        check(a == 6, "R11 write with update", a, 6);

        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            report();
            $finish;
        end
    end

endmodule